// File: doc/BRIEF.md
# Auxiliary Side-Channel Transaction Engine

This block runs one request/reply exchange on a display auxiliary side channel. Software fills a 20-byte message buffer through five 32-bit data words and then writes a control word. That word carries the byte count, the bit-clock divider, the precharge length, the reply timeout choice and a start bit. The engine waits out the precharge and then hands the request bytes, in buffer order, to a byte-wide PHY port. It then accepts reply bytes into the same buffer. It finishes with a done flag and, when the exchange fails, a timeout or receive-error flag.

Line coding and the analog front end sit outside the block. The PHY is seen as two byte streams with valid/ready handshakes, plus a strobe at twice the bit rate. On the request stream the engine holds `tx_data` and `tx_last` steady while `tx_valid` is high and `tx_ready` is low, and it never withdraws a byte once offered. On the reply stream the PHY may stall freely. The engine raises `rx_ready` only while it is waiting for a reply, so a byte offered at any other time is not taken.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset, the control word (address 0) and every data word read as 0, and `tx_valid`, `irq` and `phy_bitclk_en` are low.
- R2: Data word at address 1+k holds buffer bytes 4k..4k+3, with byte 4k in bits 31:24 and the later bytes in the lower lanes. Writes to data words are ignored while a transaction runs.
- R3: The control word has these fields: bit 31 start/busy, bit 30 done, bit 29 interrupt disable, bit 28 timeout, bits 27:26 timeout select, bit 25 receive error, bits 24:20 size, bits 19:16 precharge, bits 9:0 divider. Writing bit 31 = 1 while idle with a divider of 1..0x3FD starts a transaction, and bit 31 reads 1 from the next cycle until completion.
- R4: With precharge P, `tx_valid` first rises 2·P·US_CYCLES+1 clock edges after the edge that accepts the start.
- R5: The engine sends buffer bytes 0..min(size,20)-1 in order over the request handshake and marks the final byte with `tx_last`. Data and last are held while the PHY stalls.
- R6: `phy_bitclk_en` pulses once every DIV clock cycles while busy and never while idle.
- R7: Accepted reply bytes are stored from buffer byte 0 upward, and buffer bytes the reply does not reach keep their values. On the reply byte marked `rx_last`, busy falls and done rises in the same cycle, and the size field takes the received count, capped at 20. Bytes past the 20th are dropped.
- R8: Timeout select codes 0, 1, 2 and 3 mean 400, 600, 800 and 1600 µs (US_CYCLES cycles each). The wait is counted from the edge that accepts the last request byte. If no complete reply arrives in that time, the engine sets done and timeout and clears the size field.
- R9: A reply byte accepted with `rx_err` high ends the transaction with done and receive error set and the size field at 0.
- R10: A start with divider 0 or above 0x3FD runs no transaction. From the next cycle done and receive error are set, size is 0 and busy is 0.
- R11: While busy, a control write changes no configuration field and starts nothing. Only its clear bits act.
- R12: Writing 1 to bit 30, 28 or 25 clears that flag. Writing 0 leaves it unchanged.
- R13: `irq` is high exactly when done is set and interrupt disable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1..5 data words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq | output | 1 | Completion interrupt |
| phy_bitclk_en | output | 1 | Strobe at twice the bit rate |
| tx_valid | output | 1 | Request byte offered |
| tx_ready | input | 1 | PHY accepts request byte |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final request byte |
| rx_valid | input | 1 | Reply byte offered |
| rx_ready | output | 1 | Engine accepts reply byte |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| rx_err | input | 1 | Reply byte flagged bad by the PHY |

## Verification
Register writes take effect at the edge that samples them, so busy, the abort flags and the blocked configuration are read one cycle after the write. The first request byte is due exactly 2·P·US_CYCLES+1 edges after the start. The bench counts falling edges from the start write and looks at `tx_valid` both one cycle before and at that edge. Completion flags appear in the cycle after the final reply handshake, and a timeout appears exactly tmo·US_CYCLES+1 edges after the last request byte is taken, so the bench reads the control word at the cycle before and the cycle of that edge. All outputs are sampled at the falling edge, and inputs are driven there too.

// File: rtl/aux_pkg.sv
package aux_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEND,
    ST_WAIT
  } aux_state_e;

  localparam int CB_BUSY   = 31;
  localparam int CB_DONE   = 30;
  localparam int CB_IRQOFF = 29;
  localparam int CB_TMO    = 28;
  localparam int CB_TSEL   = 26;
  localparam int CB_RXERR  = 25;
  localparam int CB_SIZE   = 20;
  localparam int CB_PRE    = 16;

  localparam int SIZE_W = 5;
  localparam int PRE_W  = 4;
  localparam int TSEL_W = 2;
  localparam int DIV_W  = 10;
  localparam logic [DIV_W-1:0] DIV_MAX = 10'h3FD;
  localparam int TMO_MAX_US = 1600;

  function automatic int unsigned tmo_us(input logic [TSEL_W-1:0] sel);
    case (sel)
      2'd0:    return 400;
      2'd1:    return 600;
      2'd2:    return 800;
      default: return TMO_MAX_US;
    endcase
  endfunction

endpackage

// File: rtl/aux_bitclk_div.sv
module aux_bitclk_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, div_i};
  assign tick_o = run && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
  parameter  int NUM_WORDS = 5,
  localparam int NUM_BYTES = NUM_WORDS * 4,
  localparam int IDX_W     = $clog2(NUM_BYTES + 1),
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [31:0]       word_wdata,
  input  logic              byte_we,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [7:0]        byte_wdata,
  input  logic [WSEL_W-1:0] rd_word_sel,
  output logic [31:0]       rd_word,
  input  logic [IDX_W-1:0]  rd_byte_idx,
  output logic [7:0]        rd_byte
);

  logic [NUM_BYTES-1:0][7:0] byte_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam int WORD = b / 4;
    localparam int MSB  = 31 - 8 * (b % 4);
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (byte_we && byte_idx == IDX_W'(b)) begin
        q <= byte_wdata;
      end else if (word_we && word_sel == WSEL_W'(WORD)) begin
        q <= word_wdata[MSB -: 8];
      end
    end

    assign byte_q[b] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_word_sel == WSEL_W'(w)) begin
        rd_word = {byte_q[4*w], byte_q[4*w+1], byte_q[4*w+2], byte_q[4*w+3]};
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (rd_byte_idx == IDX_W'(b)) rd_byte = byte_q[b];
    end
  end

endmodule

// File: rtl/aux_seq.sv
module aux_seq
  import aux_pkg::*;
#(
  parameter  int NUM_BYTES = 20,
  parameter  int US_CYCLES = 125,
  localparam int IDX_W     = $clog2(NUM_BYTES + 1),
  localparam int CNT_W     = $clog2(TMO_MAX_US * US_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [7:0]        rd_byte_i,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o,
  output logic              fin_ok_o,
  output logic              fin_tmo_o,
  output logic              fin_err_o,
  output logic [IDX_W-1:0]  rx_cnt_o
);

  aux_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  logic [IDX_W-1:0] send_len;
  logic [IDX_W-1:0] idx_inc;
  logic [CNT_W-1:0] pre_lim;
  logic [CNT_W-1:0] tmo_lim;
  logic             rx_hs;
  logic             room;

  assign send_len = (int'(size_i) > NUM_BYTES) ? IDX_W'(NUM_BYTES) : IDX_W'(size_i);
  assign pre_lim  = CNT_W'(int'(pre_i) * 2 * US_CYCLES);
  assign tmo_lim  = CNT_W'(tmo_us(tsel_i) * US_CYCLES);

  assign busy_o   = (st_q != ST_IDLE);
  assign tx_valid = (st_q == ST_SEND);
  assign tx_last  = tx_valid && (idx_q == send_len - 1'b1);
  assign rd_idx_o = idx_q;
  assign tx_data  = rd_byte_i;
  assign rx_ready = (st_q == ST_WAIT);

  assign rx_hs     = rx_valid && rx_ready;
  assign room      = idx_q < IDX_W'(NUM_BYTES);
  assign idx_inc   = room ? idx_q + 1'b1 : idx_q;
  assign wr_en_o   = rx_hs && !rx_err && room;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = rx_data;
  assign fin_err_o = rx_hs && rx_err;
  assign fin_ok_o  = rx_hs && !rx_err && rx_last;
  assign fin_tmo_o = rx_ready && !rx_hs && (cnt_q >= tmo_lim);
  assign rx_cnt_o  = idx_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_PRE;
            cnt_q <= '0;
          end
        end
        ST_PRE: begin
          if (cnt_q >= pre_lim) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= (send_len == '0) ? ST_WAIT : ST_SEND;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (tx_last) begin
              st_q  <= ST_WAIT;
              cnt_q <= '0;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (fin_ok_o || fin_err_o || fin_tmo_o) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rx_hs) idx_q <= idx_inc;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_pkg::*;
#(
  parameter  int NUM_WORDS = 5,
  parameter  int US_CYCLES = 125,
  localparam int NUM_BYTES = NUM_WORDS * 4,
  localparam int IDX_W     = $clog2(NUM_BYTES + 1),
  localparam int ADDR_W    = $clog2(NUM_WORDS + 1),
  localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              phy_bitclk_en,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err
);

  logic              done_q, irqoff_q, tmo_q, rxerr_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [SIZE_W-1:0] size_q;
  logic [PRE_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;

  logic              busy;
  logic              fin_ok, fin_tmo, fin_err;
  logic [IDX_W-1:0]  rx_cnt;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [7:0]        rd_byte, wr_data;
  logic              wr_en;
  logic [31:0]       rd_word;
  logic [31:0]       ctrl_word;

  logic              ctrl_wr, go_req, div_ok, start, abort, data_we;
  logic [DIV_W-1:0]  wdiv;
  logic [WSEL_W-1:0] word_sel;

  assign wdiv     = reg_wdata[DIV_W-1:0];
  assign ctrl_wr  = reg_we && (reg_addr == '0);
  assign go_req   = ctrl_wr && reg_wdata[CB_BUSY] && !busy;
  assign div_ok   = (wdiv != '0) && (wdiv <= DIV_MAX);
  assign start    = go_req && div_ok;
  assign abort    = go_req && !div_ok;
  assign word_sel = WSEL_W'(reg_addr - 1'b1);
  assign data_we  = reg_we && (reg_addr != '0) &&
                    (reg_addr <= ADDR_W'(NUM_WORDS)) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      irqoff_q <= 1'b0;
      tmo_q    <= 1'b0;
      rxerr_q  <= 1'b0;
      tsel_q   <= '0;
      size_q   <= '0;
      pre_q    <= '0;
      div_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        if (reg_wdata[CB_DONE])  done_q  <= 1'b0;
        if (reg_wdata[CB_TMO])   tmo_q   <= 1'b0;
        if (reg_wdata[CB_RXERR]) rxerr_q <= 1'b0;
        if (!busy) begin
          irqoff_q <= reg_wdata[CB_IRQOFF];
          tsel_q   <= reg_wdata[CB_TSEL +: TSEL_W];
          size_q   <= reg_wdata[CB_SIZE +: SIZE_W];
          pre_q    <= reg_wdata[CB_PRE +: PRE_W];
          div_q    <= wdiv;
        end
      end
      if (abort || fin_err) begin
        done_q  <= 1'b1;
        rxerr_q <= 1'b1;
        size_q  <= '0;
      end
      if (fin_tmo) begin
        done_q <= 1'b1;
        tmo_q  <= 1'b1;
        size_q <= '0;
      end
      if (fin_ok) begin
        done_q <= 1'b1;
        size_q <= SIZE_W'(rx_cnt);
      end
    end
  end

  assign ctrl_word = {busy, done_q, irqoff_q, tmo_q, tsel_q, rxerr_q,
                      size_q, pre_q, 6'b0, div_q};
  assign reg_rdata = (reg_addr == '0) ? ctrl_word : rd_word;
  assign irq       = done_q && !irqoff_q;

  aux_byte_buf #(.NUM_WORDS(NUM_WORDS)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_we    (data_we),
    .word_sel   (word_sel),
    .word_wdata (reg_wdata),
    .byte_we    (wr_en),
    .byte_idx   (wr_idx),
    .byte_wdata (wr_data),
    .rd_word_sel(word_sel),
    .rd_word    (rd_word),
    .rd_byte_idx(rd_idx),
    .rd_byte    (rd_byte)
  );

  aux_seq #(.NUM_BYTES(NUM_BYTES), .US_CYCLES(US_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .size_i   (size_q),
    .pre_i    (pre_q),
    .tsel_i   (tsel_q),
    .rd_idx_o (rd_idx),
    .rd_byte_i(rd_byte),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .rx_err   (rx_err),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data),
    .busy_o   (busy),
    .fin_ok_o (fin_ok),
    .fin_tmo_o(fin_tmo),
    .fin_err_o(fin_err),
    .rx_cnt_o (rx_cnt)
  );

  aux_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div_i (div_q),
    .tick_o(phy_bitclk_en)
  );

endmodule

// File: rtl/aux_xact_engine_chk.sv
module aux_xact_engine_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_q,
  input logic              tmo_q,
  input logic              rxerr_q,
  input logic [4:0]        size_q,
  input logic [3:0]        pre_q,
  input logic [1:0]        tsel_q,
  input logic [9:0]        div_q,
  input logic              bitclk_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata
);

  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == '0);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R5

  AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q); // R7

  AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bitclk_en); // R6

  AST_FAIL_SIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) || $rose(rxerr_q) |-> done_q && size_q == 5'd0); // R8

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(size_q) && $stable(pre_q) &&
                            $stable(tsel_q) && $stable(div_q)); // R11

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[30] && !reg_wdata[31] && !busy |=> !done_q); // R12

  AST_BAD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[31] && !busy &&
    (reg_wdata[9:0] == 10'd0 || reg_wdata[9:0] > 10'h3FD)
    |=> done_q && rxerr_q && !busy); // R10

endmodule

bind aux_xact_engine aux_xact_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done_q   (done_q),
  .tmo_q    (tmo_q),
  .rxerr_q  (rxerr_q),
  .size_q   (size_q),
  .pre_q    (pre_q),
  .tsel_q   (tsel_q),
  .div_q    (div_q),
  .bitclk_en(phy_bitclk_en),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_aux_xact_engine.sv
module tb_aux_xact_engine;

  localparam int US = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, phy_bitclk_en;
  logic        tx_valid, tx_last, rx_ready;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;

  always #4 clk = ~clk;

  aux_xact_engine #(.NUM_WORDS(5), .US_CYCLES(US)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .phy_bitclk_en(phy_bitclk_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request sink with optional back-pressure
  bit         bp_en = 1'b0;
  logic [7:0] sink_buf [32];
  int         sink_cnt = 0;
  int         sink_last_at = -1;

  always @(negedge clk) begin
    tx_ready = bp_en ? ~tx_ready : 1'b1;
    if (tx_valid && tx_ready) begin
      if (sink_cnt < 32) sink_buf[sink_cnt] = tx_data;
      if (tx_last) sink_last_at = sink_cnt;
      sink_cnt++;
    end
  end

  // strobe monitor
  int cyc = 0, last_tick = 0, tick_cnt = 0, gap_bad = 0, exp_div = 1;
  bit have_tick = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (phy_bitclk_en) begin
      if (have_tick && (cyc - last_tick) != exp_div) gap_bad++;
      have_tick = 1'b1;
      last_tick = cyc;
      tick_cnt++;
    end
  end

  function automatic logic [31:0] mk(bit go, bit clr, bit irqoff, logic [1:0] tsel,
                                     logic [4:0] size, logic [3:0] pre, logic [9:0] div);
    return {go, clr, irqoff, clr, tsel, clr, size, pre, 6'b0, div};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = '0;
  endtask

  task automatic reply(input int n, input int err_at, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = base + 8'(i);
      rx_last  = (i == n - 1);
      rx_err   = (i == err_at);
      if (i == err_at) break;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic sink_clear();
    sink_cnt = 0; sink_last_at = -1; have_tick = 1'b0; gap_bad = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk_eq("R1 ctrl", v, 32'h0);
    rd(3'd3, v); chk_eq("R1 data", v, 32'h0);
    chk_eq("R1 outputs", {tx_valid, irq, phy_bitclk_en}, 3'b000);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    for (int k = 0; k < 5; k++)
      wr(3'(k + 1), 32'h10111213 + 32'(k) * 32'h04040404);
    rd(3'd3, v); chk_eq("R2 readback", v, 32'h18191A1B);
    sink_clear(); bp_en = 1'b1; exp_div = 3;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd6, 4'd1, 10'd3));
    rd(3'd0, v); chk_eq("R3 busy+size", {v[31], v[24:20]}, {1'b1, 5'd6});
    wait (sink_cnt == 6);
    for (int i = 0; i < 6; i++) chk_eq("R5 byte order", sink_buf[i], 8'h10 + 8'(i));
    chk_eq("R5 last", sink_last_at, 5);
    wr(3'd1, 32'hFFFFFFFF);
    reply(3, -1, 8'hA0);
    rd(3'd0, v); chk_eq("R7 busy/done/size", {v[31:30], v[24:20]}, {2'b01, 5'd3});
    chk_eq("R13 irq", irq, 1'b1);
    rd(3'd1, v); chk_eq("R2 R7 word0", v, 32'hA0A1A213);
    rd(3'd2, v); chk_eq("R7 untouched", v, 32'h14151617);
    chk_eq("R6 gap", gap_bad, 0);
    chk_eq("R6 ticked", tick_cnt > 0, 1);
    begin
      int t0 = tick_cnt;
      repeat (20) @(negedge clk);
      chk_eq("R6 idle", tick_cnt, t0);
    end
    bp_en = 1'b0;
  endtask

  task automatic t_precharge();
    sink_clear(); exp_div = 5;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd1, 4'd3, 10'd5));
    repeat (12) @(negedge clk);
    chk_eq("R4 quiet", tx_valid, 1'b0);
    @(negedge clk);
    chk_eq("R4 first byte", tx_valid, 1'b1);
    reply(1, -1, 8'h01);
    chk_eq("R6 gap div5", gap_bad, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    sink_clear(); exp_div = 2;
    wr(3'd0, mk(1, 1, 1, 2'd0, 5'd2, 4'd0, 10'd2));
    wait (sink_cnt == 2);
    repeat (801) @(negedge clk);
    rd(3'd0, v); chk_eq("R8 still busy", v[31:30], 2'b10);
    @(negedge clk);
    rd(3'd0, v);
    chk_eq("R8 timeout", {v[31:30], v[28], v[25], v[24:20]}, {2'b01, 2'b10, 5'd0});
    chk_eq("R13 masked", irq, 1'b0);
  endtask

  task automatic t_rxerr();
    logic [31:0] v;
    sink_clear(); exp_div = 2;
    wr(3'd0, mk(1, 1, 0, 2'd3, 5'd1, 4'd0, 10'd2));
    reply(2, 0, 8'h55);
    rd(3'd0, v);
    chk_eq("R9 rxerr", {v[31:30], v[28], v[25], v[24:20]}, {2'b01, 2'b01, 5'd0});
  endtask

  task automatic t_baddiv();
    logic [31:0] v;
    sink_clear();
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd4, 4'd0, 10'd0));
    rd(3'd0, v);
    chk_eq("R10 div0", {v[31:30], v[25], v[24:20]}, {3'b011, 5'd0});
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd4, 4'd0, 10'h3FE));
    rd(3'd0, v);
    chk_eq("R10 div3FE", {v[31:30], v[25], v[24:20]}, {3'b011, 5'd0});
    repeat (10) @(negedge clk);
    chk_eq("R10 nothing sent", sink_cnt, 0);
    exp_div = 10'h3FD;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd0, 4'd0, 10'h3FD));
    rd(3'd0, v); chk_eq("R10 max div starts", v[31], 1'b1);
    reply(1, -1, 8'h77);
  endtask

  task automatic t_busy_go();
    logic [31:0] v;
    sink_clear(); exp_div = 2;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd3, 4'd2, 10'd2));
    wr(3'd0, mk(1, 0, 0, 2'd1, 5'd7, 4'd0, 10'd4));
    rd(3'd0, v);
    chk_eq("R11 cfg kept", {v[31], v[24:20], v[9:0]}, {1'b1, 5'd3, 10'd2});
    reply(1, -1, 8'h33);
    repeat (30) @(negedge clk);
    rd(3'd0, v);
    chk_eq("R11 one xact", {sink_cnt[7:0], v[31]}, {8'd3, 1'b0});
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd1, 4'd0, 10'd0));
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk_eq("R12 zero keeps", {v[30], v[25]}, 2'b11);
    wr(3'd0, 32'h4000_0000);
    rd(3'd0, v); chk_eq("R12 clear done", {v[30], v[25]}, 2'b01);
    wr(3'd0, 32'h0200_0000);
    rd(3'd0, v); chk_eq("R12 clear rxerr", {v[30], v[25]}, 2'b00);
  endtask

  task automatic t_cap();
    logic [31:0] v;
    sink_clear(); exp_div = 2;
    wr(3'd0, mk(1, 1, 0, 2'd0, 5'd25, 4'd0, 10'd2));
    wait (sink_cnt == 20);
    repeat (10) @(negedge clk);
    chk_eq("R5 cap sent", sink_cnt, 20);
    chk_eq("R5 cap last", sink_last_at, 19);
    reply(22, -1, 8'h40);
    rd(3'd0, v); chk_eq("R7 cap count", v[24:20], 5'd20);
    rd(3'd5, v); chk_eq("R7 cap word4", v, 32'h50515253);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_precharge();
    t_timeout();
    t_rxerr();
    t_baddiv();
    t_busy_go();
    t_w1c();
    t_cap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule